// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns three exception requests (external interrupt, software interrupt, undefined instruction) into the state updates a processor core performs when it enters an exception handler. In the cycle after a request is accepted it issues one set of register-file write strobes. The link register gets a return address. The saved-status register gets the status word as it stood before entry. The live status word gets a new value: the mode field is replaced, the interrupt mask is set, and the core is forced back to 32-bit instruction state. The program counter is loaded with a fixed per-type vector, and a pipeline-flush pulse is raised.

The core drives the current PC and status word every cycle. The instruction width is taken from the narrow-state bit of the status word. The external interrupt line is a level that the requester holds until it is serviced. It is honoured only while unmasked. Even when it is masked, every cycle it is high produces a wake pulse that clears the core's halted flag. The banked register storage and the instruction decoder are outside this block.

Top module: `exc_entry_seq`

## Requirements
- R1: Whenever `irq_req` is high at a clock edge, `halt_clr` is high for the following cycle. This holds whether the interrupt is masked or not.
- R2: An interrupt request seen while status bit 7 (interrupt mask) is 1, with no other request, produces no write strobe, no mode change and no flush.
- R3: On interrupt entry, `lr_data` equals PC − width + 4. The width is 2 when status bit 5 (narrow state) is 1 and 4 otherwise.
- R4: On software-interrupt or undefined-instruction entry, `lr_data` equals PC − width with no added term. The value wraps modulo 2^32.
- R5: Each entry type selects its own mode and vector. Interrupt uses mode 5'h12 and vector 0x18. Software interrupt uses mode 5'h13 and vector 0x08. Undefined instruction uses mode 5'h1B and vector 0x04.
- R6: On every entry, `spsr_data` equals the status word sampled with the request.
- R7: On every entry, `status_data` is the old status word with bits [4:0] replaced by the new mode, bit 5 cleared and bit 7 set. Bits [31:8] and bit 6 are kept.
- R8: Priority is undefined instruction over software interrupt over interrupt. A coincident interrupt is not taken in that cycle.
- R9: Every entry raises `flush` together with `lr_we`, `spsr_we`, `status_we`, `mode_chg` and `pc_we` for exactly one cycle.
- R10: While `rst_n` is low and after its release, all strobes and `halt_clr` are low until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_in | input | 32 | Current program counter |
| status_in | input | 32 | Current status word (mode [4:0], narrow bit 5, mask bit 7) |
| irq_req | input | 1 | External interrupt level |
| swi_req | input | 1 | Software-interrupt request |
| und_req | input | 1 | Undefined-instruction request |
| halt_clr | output | 1 | Wake pulse clearing the halted flag |
| lr_we | output | 1 | Link-register write strobe |
| lr_data | output | 32 | Return address |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_data | output | 32 | Status word before entry |
| status_we | output | 1 | Live status write strobe |
| status_data | output | 32 | Status word after entry |
| mode_chg | output | 1 | Mode-change strobe |
| new_mode | output | 5 | Mode being entered |
| pc_we | output | 1 | Program-counter load strobe |
| pc_target | output | 32 | Exception vector |
| flush | output | 1 | Pipeline refill pulse |

## Verification
Two functions can fall in the same cycle: the wake pulse from an interrupt line and an entry caused by another request. A third case is two or three entry requests arriving together. The bench provokes these by raising the interrupt alongside a software or undefined request, with the mask both set and clear. It then checks that the wake pulse still appears and that only the higher-priority entry is taken, with its own vector, mode and return offset. The same vector table also covers a masked interrupt alone, where the wake pulse must appear while every write strobe stays low.

// File: rtl/exc_entry_seq.sv
`timescale 1ns/1ps
module exc_entry_seq #(
  parameter int          W       = 32,
  parameter logic [W-1:0] UND_VEC = 32'h0000_0004,
  parameter logic [W-1:0] SWI_VEC = 32'h0000_0008,
  parameter logic [W-1:0] IRQ_VEC = 32'h0000_0018
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] status_in,
  input  logic         irq_req,
  input  logic         swi_req,
  input  logic         und_req,
  output logic         halt_clr,
  output logic         lr_we,
  output logic [W-1:0] lr_data,
  output logic         spsr_we,
  output logic [W-1:0] spsr_data,
  output logic         status_we,
  output logic [W-1:0] status_data,
  output logic         mode_chg,
  output logic [4:0]   new_mode,
  output logic         pc_we,
  output logic [W-1:0] pc_target,
  output logic         flush
);
  localparam int         MASK_BIT = 7;
  localparam int         NARW_BIT = 5;
  localparam logic [4:0] M_IRQ = 5'h12;
  localparam logic [4:0] M_SVC = 5'h13;
  localparam logic [4:0] M_UND = 5'h1B;

  logic         irq_ok, take;
  logic [4:0]   mode_sel;
  logic [W-1:0] vec_sel, width, ret, nstat;
  logic         entry_q, wake_q;

  assign irq_ok = irq_req & ~status_in[MASK_BIT];
  assign take   = und_req | swi_req | irq_ok;
  assign width  = status_in[NARW_BIT] ? W'(2) : W'(4);

  always_comb begin
    if (und_req) begin
      mode_sel = M_UND;
      vec_sel  = UND_VEC;
      ret      = pc_in - width;
    end else if (swi_req) begin
      mode_sel = M_SVC;
      vec_sel  = SWI_VEC;
      ret      = pc_in - width;
    end else begin
      mode_sel = M_IRQ;
      vec_sel  = IRQ_VEC;
      ret      = pc_in - width + W'(4);
    end
    nstat           = status_in;
    nstat[4:0]      = mode_sel;
    nstat[NARW_BIT] = 1'b0;
    nstat[MASK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q     <= 1'b0;
      wake_q      <= 1'b0;
      lr_data     <= '0;
      spsr_data   <= '0;
      status_data <= '0;
      new_mode    <= '0;
      pc_target   <= '0;
    end else begin
      entry_q <= take;
      wake_q  <= irq_req;
      if (take) begin
        lr_data     <= ret;
        spsr_data   <= status_in;
        status_data <= nstat;
        new_mode    <= mode_sel;
        pc_target   <= vec_sel;
      end
    end
  end

  assign halt_clr  = wake_q;
  assign lr_we     = entry_q;
  assign spsr_we   = entry_q;
  assign status_we = entry_q;
  assign mode_chg  = entry_q;
  assign pc_we     = entry_q;
  assign flush     = entry_q;

  p_wake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> halt_clr);
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && status_in[MASK_BIT] && !swi_req && !und_req) |=> !flush && !lr_we);
  p_irq_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !status_in[MASK_BIT] && !swi_req && !und_req) |=>
      lr_data == $past(pc_in) - ($past(status_in[NARW_BIT]) ? W'(2) : W'(4)) + W'(4));
  p_swi_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_req && !und_req) |=>
      lr_data == $past(pc_in) - ($past(status_in[NARW_BIT]) ? W'(2) : W'(4)));
  p_und_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    und_req |=> pc_we && pc_target == UND_VEC && new_mode == M_UND);
  p_spsr_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (und_req || swi_req || (irq_req && !status_in[MASK_BIT])) |=> spsr_data == $past(status_in));
  p_new_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |-> status_data[MASK_BIT] && !status_data[NARW_BIT] && status_data[4:0] == new_mode);
  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_req && irq_req && !und_req) |=> new_mode == M_SVC);
endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pc_in, status_in;
  logic        irq_req, swi_req, und_req;
  logic        halt_clr, lr_we, spsr_we, status_we, mode_chg, pc_we, flush;
  logic [31:0] lr_data, spsr_data, status_data, pc_target;
  logic [4:0]  new_mode;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .status_in(status_in),
    .irq_req(irq_req), .swi_req(swi_req), .und_req(und_req),
    .halt_clr(halt_clr), .lr_we(lr_we), .lr_data(lr_data),
    .spsr_we(spsr_we), .spsr_data(spsr_data), .status_we(status_we),
    .status_data(status_data), .mode_chg(mode_chg), .new_mode(new_mode),
    .pc_we(pc_we), .pc_target(pc_target), .flush(flush));

  // {und,swi,irq}, status, pc, expect_take, expect_vector
  localparam int NV = 10;
  localparam logic [75:0] VEC [NV] = '{
    {3'b001, 32'hF000_001F, 32'h0000_1000, 1'b1, 8'h18},
    {3'b001, 32'hA000_007F, 32'h0000_2002, 1'b1, 8'h18},
    {3'b001, 32'h0000_009F, 32'h0000_3000, 1'b0, 8'h00},
    {3'b010, 32'h1000_0010, 32'h0000_0100, 1'b1, 8'h08},
    {3'b010, 32'h0000_0030, 32'h0000_0102, 1'b1, 8'h08},
    {3'b100, 32'h0000_001F, 32'h0000_0000, 1'b1, 8'h04},
    {3'b100, 32'h0000_003F, 32'h0000_0000, 1'b1, 8'h04},
    {3'b111, 32'h0000_0010, 32'h0000_4000, 1'b1, 8'h04},
    {3'b011, 32'h0000_0030, 32'h0000_5006, 1'b1, 8'h08},
    {3'b011, 32'h0000_00B0, 32'h0000_6000, 1'b1, 8'h08}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_req = 1'b0; swi_req = 1'b0; und_req = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pc_in = '0; status_in = '0; idle();
    // R10: strobes low under reset, even with requests pending
    und_req = 1'b1; irq_req = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", {26'b0, lr_we, spsr_we, status_we, mode_chg, pc_we, flush}, 32'h0);
    chk("R10", {31'b0, halt_clr}, 32'h0);
    @(negedge clk); idle(); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10", {31'b0, flush}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  rq;
      logic [31:0] st, pc, w, elr, est;
      logic [4:0]  em;
      logic        etake;
      logic [7:0]  evec;
      {rq, st, pc, etake, evec} = VEC[i];
      @(negedge clk);
      und_req = rq[2]; swi_req = rq[1]; irq_req = rq[0];
      status_in = st; pc_in = pc;
      @(posedge clk); #1;
      w = st[5] ? 32'd2 : 32'd4;
      if (rq[2]) begin em = 5'h1B; elr = pc - w; end
      else if (rq[1]) begin em = 5'h13; elr = pc - w; end
      else begin em = 5'h12; elr = pc - w + 32'd4; end
      est = {st[31:8], 1'b1, st[6], 1'b0, em};
      chk("R1", {31'b0, halt_clr}, {31'b0, rq[0]});
      chk("R9", {26'b0, lr_we, spsr_we, status_we, mode_chg, pc_we, flush},
          etake ? 32'h3F : 32'h0);
      if (etake) begin
        chk(rq[2] | rq[1] ? "R4" : "R3", lr_data, elr);
        chk(rq[2] ? "R5" : "R8", {24'b0, pc_target[7:0]}, {24'b0, evec});
        chk("R5", {27'b0, new_mode}, {27'b0, em});
        chk("R6", spsr_data, st);
        chk("R7", status_data, est);
      end else begin
        chk("R2", {31'b0, mode_chg}, 32'h0);
      end
      @(negedge clk); idle();
      #1;
      // R9: flush lasts a single cycle
      @(posedge clk); #1;
      chk("R9", {31'b0, flush}, 32'h0);
    end

    // R1/R8: held masked interrupt keeps waking, never enters
    @(negedge clk); status_in = 32'h0000_0092; irq_req = 1'b1;
    @(posedge clk); #1;
    chk("R1", {31'b0, halt_clr}, 32'h1);
    @(posedge clk); #1;
    chk("R2", {31'b0, flush}, 32'h0);
    @(negedge clk); idle();

    // R10: reset in mid-entry drops strobes
    @(negedge clk); swi_req = 1'b1; status_in = 32'h10;
    @(negedge clk); idle(); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R10", {31'b0, flush}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule